// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between an internal single-beat request bus and an external asynchronous static RAM of 512K bytes (19 address lines, 8 data lines). A requester presents a read or a write with an address and, for writes, a data byte. The controller then drives the memory's active-low select, output-enable and write-strobe lines through a fixed sequence of phases. Each phase length is a count of clock cycles. The counts are derived at elaboration from nanosecond timing parameters and a clock-period parameter.

Each count is the ceiling of the nanosecond value divided by the clock period, and is never less than one cycle. After reset the controller waits a power-up interval before it starts any access. It releases output enable for the whole of a write, so the memory never drives the shared data lines while the controller does. Completion is signalled by a one-cycle acknowledge pulse, and read data is returned with that pulse.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycles after it, chip select, output enable and write strobe are high (inactive), data drive is off and acknowledge is low.
- R2: After reset is released, chip select stays high and no acknowledge is given for ceil(T_PWR_NS/CLK_NS) cycles. A request that is already pending is then accepted on the following cycle, so select first goes low on cycle ceil(T_PWR_NS/CLK_NS)+1.
- R3: A read holds select and output enable low and write strobe high for max(ceil(T_AA_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)) cycles. The data lines are sampled at the end of the last of those cycles. Acknowledge follows in the next cycle with that byte on the read-data output. The read-data output keeps its value through later writes until the next read.
- R4: A write first spends max(1, ceil(T_HZ_NS/CLK_NS)) cycles with select low, write strobe high, output enable high and data drive off.
- R5: The write strobe is then low for exactly max(ceil(T_PWE_NS), ceil(T_SD_NS), ceil(T_AW_NS)) cycles, counting each value in clock periods. The controller's data drive is on only in those cycles, and the driven byte stays stable throughout.
- R6: Data drive is never on unless select and write strobe are low and output enable is high. Output enable is low only while select is low and write strobe is high.
- R7: A write holds select low for max(the setup plus strobe cycles, ceil(T_WC_NS/CLK_NS)) cycles. Recovery cycles with the strobe high pad it when needed.
- R8: Address and write data are captured when a request is accepted. Changes on the request inputs during the access have no effect, and the memory address stays stable while select is low.
- R9: Acknowledge is a single-cycle pulse during which select is high. A new request is accepted only in the idle state that follows, and data written to an address is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data, valid with acknowledge of a read |
| sram_addr | output | 19 | Memory address lines |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dout | output | 8 | Data toward the memory |
| sram_dout_en | output | 1 | Drive enable for sram_dout |
| sram_din | input | 8 | Data from the memory |

## Verification
The bench builds the controller with a 4 ns clock and a 100 ns power-up interval, which gives 25 waiting cycles, so the boundary of the power-up wait can be checked cycle by cycle. The access time of 15 ns is not a whole multiple of the clock, so the ceiling rounding decides whether the sampled read byte is valid or not. The write cycle time is set to 25 ns, which needs 7 cycles against 5 cycles of setup plus strobe. This makes the recovery padding of the write path visible at the ports.

// File: rtl/asram_pkg.sv
// Shared types and elaboration-time helpers for the SRAM controller.
// Assumes all timing values are non-negative integers in nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_PWR,
        ST_IDLE,
        ST_RD,
        ST_WSU,
        ST_WPL,
        ST_WREC,
        ST_ACK
    } seq_state_t;

    // Cycles needed to cover ns at period clk_ns, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
// Phase down-counter: loaded with (length - 1) when a phase begins,
// reports done on the last cycle of the phase. Assumes load_val fits W.
module asram_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and stay.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/asram_pwr_wait.sv
// Power-up interval counter: ok rises after CYC cycles following the
// release of reset and stays high. Assumes CYC >= 1.
module asram_pwr_wait #(
    parameter int CYC = 100,
    localparam int W = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic ok
);

    logic [W-1:0] cnt;

    // Count down the remaining wait after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= W'(CYC - 1);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign ok = (cnt == '0);

endmodule

// File: rtl/asram_dpath.sv
// Address/data holding registers: captures request fields on acceptance
// and the memory's data lines at the end of a read. Assumes accept and
// capture are never high in the same cycle.
module asram_dpath #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_din,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic [DW-1:0] rdata
);

    // Hold address and write byte for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dout <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
        end
    end

    // Sample read data on the last cycle of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (capture) rdata <= mem_din;
    end

endmodule

// File: rtl/asram_seq.sv
// Access sequencer: steps through power-up, idle, read, write setup,
// write strobe, write recovery and acknowledge. All memory strobes are
// registered from the next state so they change only at clock edges.
// Assumes the phase timer reports done on the last cycle of each phase.
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_CYC  = 2,
    parameter int SU_CYC  = 1,
    parameter int PW_CYC  = 2,
    parameter int REC_CYC = 0,
    parameter int TW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          accept,
    output logic          capture,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          dout_en,
    output logic          ack
);

    localparam int REC_LD = (REC_CYC > 0) ? REC_CYC - 1 : 0;

    seq_state_t state, nxt;

    // Next-state and phase-timer load decisions.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_PWR:  if (pwr_ok) nxt = ST_IDLE;
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        nxt     = ST_WSU;
                        tmr_val = TW'(SU_CYC - 1);
                    end else begin
                        nxt     = ST_RD;
                        tmr_val = TW'(RD_CYC - 1);
                    end
                end
            end
            ST_RD:   if (tmr_done) nxt = ST_ACK;
            ST_WSU: begin
                if (tmr_done) begin
                    nxt      = ST_WPL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PW_CYC - 1);
                end
            end
            ST_WPL: begin
                if (tmr_done) begin
                    if (REC_CYC > 0) begin
                        nxt      = ST_WREC;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(REC_LD);
                    end else begin
                        nxt = ST_ACK;
                    end
                end
            end
            ST_WREC: if (tmr_done) nxt = ST_ACK;
            ST_ACK:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign accept  = (state == ST_IDLE) && req_valid;
    assign capture = (state == ST_RD) && tmr_done;

    // State register and registered memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_PWR;
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            dout_en <= 1'b0;
            ack     <= 1'b0;
        end else begin
            state   <= nxt;
            ce_n    <= !(nxt inside {ST_RD, ST_WSU, ST_WPL, ST_WREC});
            oe_n    <= (nxt != ST_RD);
            we_n    <= (nxt != ST_WPL);
            dout_en <= (nxt == ST_WPL);
            ack     <= (nxt == ST_ACK);
        end
    end

    // Length of the current write-strobe low pulse, for the checks below.
    logic [TW-1:0] we_lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || we_n) we_lo_cnt <= '0;
        else                we_lo_cnt <= we_lo_cnt + 1'b1;
    end

    AST_PWR_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWR) |-> (ce_n && !ack)); // R2
    AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!we_n && !ce_n && oe_n)); // R6
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !ce_n)); // R6
    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_lo_cnt == TW'(PW_CYC))); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R9
    AST_ACK_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ce_n); // R9

endmodule

// File: rtl/asram_ctrl.sv
// Top of the asynchronous SRAM controller. Converts nanosecond timing
// parameters into cycle counts and wires the power-up counter, phase
// timer, sequencer and data path together. Assumes the requester holds
// req_valid and its fields until req_ack and drops req_valid on it.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW        = 19,
    parameter int DW        = 8,
    parameter int CLK_NS    = 10,
    parameter int T_PWR_NS  = 1000,
    parameter int T_AA_NS   = 15,
    parameter int T_RC_NS   = 15,
    parameter int T_WC_NS   = 15,
    parameter int T_PWE_NS  = 12,
    parameter int T_SD_NS   = 8,
    parameter int T_AW_NS   = 12,
    parameter int T_HZ_NS   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] req_rdata,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic [DW-1:0] sram_dout,
    output logic          sram_dout_en,
    input  logic [DW-1:0] sram_din
);

    localparam int PWR_CYC = ns2cyc(T_PWR_NS, CLK_NS);
    localparam int RD_CYC  = imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS));
    localparam int SU_CYC  = ns2cyc(T_HZ_NS, CLK_NS);
    localparam int PW_CYC  = imax(ns2cyc(T_PWE_NS, CLK_NS),
                                  imax(ns2cyc(T_SD_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)));
    localparam int WC_CYC  = ns2cyc(T_WC_NS, CLK_NS);
    localparam int REC_CYC = (WC_CYC > SU_CYC + PW_CYC) ? WC_CYC - SU_CYC - PW_CYC : 0;
    localparam int MAX_CYC = imax(imax(RD_CYC, SU_CYC), imax(PW_CYC, REC_CYC));
    localparam int TW      = $clog2(MAX_CYC + 1);

    logic          pwr_ok;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          accept;
    logic          capture;

    asram_pwr_wait #(.CYC(PWR_CYC)) u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .ok    (pwr_ok)
    );

    asram_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    asram_seq #(
        .RD_CYC  (RD_CYC),
        .SU_CYC  (SU_CYC),
        .PW_CYC  (PW_CYC),
        .REC_CYC (REC_CYC),
        .TW      (TW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .dout_en   (sram_dout_en),
        .ack       (req_ack)
    );

    asram_dpath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_din   (sram_din),
        .mem_addr  (sram_addr),
        .mem_dout  (sram_dout),
        .rdata     (req_rdata)
    );

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R8
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_dout)); // R5
    AST_NO_ACCESS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> sram_ce_n); // R9

endmodule

// File: tb/sim_asram_ctrl.sv
// Self-checking bench with a behavioural asynchronous SRAM model.
module sim_asram_ctrl;

    localparam int CLK_NS  = 4;
    localparam int PWR_NS  = 100;
    localparam int WC_NS   = 25;
    localparam int PWR_CK  = (PWR_NS + CLK_NS - 1) / CLK_NS;   // 25
    localparam int AA_CK   = (15 + CLK_NS - 1) / CLK_NS;       // 4
    localparam int RD_CK   = AA_CK;                            // read cycle also 15 ns
    localparam int SU_CK   = (7 + CLK_NS - 1) / CLK_NS;        // 2
    localparam int PW_CK   = (12 + CLK_NS - 1) / CLK_NS;       // 3
    localparam int WC_CK   = (WC_NS + CLK_NS - 1) / CLK_NS;    // 7
    localparam int WRCE_CK = (WC_CK > SU_CK + PW_CK) ? WC_CK : SU_CK + PW_CK;
    localparam int RD_LAT  = RD_CK + 1;
    localparam int WR_LAT  = WRCE_CK + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  req_rdata;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dout_en;
    logic [7:0]  sram_dout;
    logic [7:0]  din_m = 8'hEE;

    always #2 clk = ~clk;

    asram_ctrl #(
        .CLK_NS   (CLK_NS),
        .T_PWR_NS (PWR_NS),
        .T_WC_NS  (WC_NS)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ack      (req_ack),
        .req_rdata    (req_rdata),
        .sram_addr    (sram_addr),
        .sram_ce_n    (sram_ce_n),
        .sram_oe_n    (sram_oe_n),
        .sram_we_n    (sram_we_n),
        .sram_dout    (sram_dout),
        .sram_dout_en (sram_dout_en),
        .sram_din     (din_m)
    );

    // ---------------- memory model and bus monitor ----------------
    logic [7:0]  mem [logic [18:0]];
    int          rd_cnt = 0, su_cnt = 0, pw_cnt = 0, ce_cnt = 0;
    int          last_su = 0, last_pw = 0, last_ce = 0, mon_err = 0;
    bit          pend = 0, post = 0;
    logic [18:0] paddr = '0, ce_addr = '0;
    logic [7:0]  pdata = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_ce_n) begin
                if (ce_cnt > 0 && sram_addr !== ce_addr) mon_err++;
                ce_addr = sram_addr;
                ce_cnt++;
            end else if (ce_cnt > 0) begin
                last_ce = ce_cnt;
                ce_cnt  = 0;
            end
            if (sram_dout_en && !(!sram_we_n && !sram_ce_n && sram_oe_n)) mon_err++;
            if (!sram_ce_n && !sram_we_n) begin
                if (!pend) begin
                    last_su = su_cnt;
                    pend    = 1;
                    paddr   = sram_addr;
                    pdata   = sram_dout;
                    pw_cnt  = 0;
                end else if (sram_dout !== pdata) mon_err++;
                if (!sram_dout_en) mon_err++;
                pw_cnt++;
            end else if (pend) begin
                mem[paddr] = pdata;
                last_pw    = pw_cnt;
                pend       = 0;
                post       = 1;
            end
            if (sram_ce_n) begin
                su_cnt = 0;
                post   = 0;
            end else if (sram_we_n && sram_oe_n && !post) su_cnt++;
            if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_cnt++;
            else rd_cnt = 0;
            if (rd_cnt >= AA_CK) din_m = mem.exists(sram_addr) ? mem[sram_addr] : 8'h00;
            else                 din_m = 8'hEE;
        end
    end

    // ---------------- checking helpers ----------------
    int checks = 0, errors = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Runs one access from a negedge; returns cycles to ack and select at ack.
    task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                          output int lat, output logic ce_at_ack);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        lat = 0;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
        end while (!req_ack && lat < 1000);
        ce_at_ack = sram_ce_n;
        req_valid = 0;
    endtask

    // {write, addr, wdata, expected read byte}
    localparam logic [35:0] VEC [9] = '{
        {1'b1, 19'h00000, 8'h5A, 8'h00},
        {1'b1, 19'h7FFFF, 8'hA5, 8'h00},
        {1'b0, 19'h00000, 8'h00, 8'h5A},
        {1'b0, 19'h7FFFF, 8'h00, 8'hA5},
        {1'b1, 19'h2AAAA, 8'hC3, 8'h00},
        {1'b0, 19'h2AAAA, 8'h00, 8'hC3},
        {1'b1, 19'h00000, 8'h0F, 8'h00},
        {1'b0, 19'h00000, 8'h00, 8'h0F},
        {1'b0, 19'h7FFFF, 8'h00, 8'hA5}
    };

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int n;
        int lat;
        logic ce_ack;
        bit ack_seen;
        logic [7:0] last_rd;

        // R1: reset state, with a write request already pending
        req_valid = 1; req_write = 1; req_addr = 19'h00100; req_wdata = 8'h77;
        repeat (3) @(negedge clk);
        chk(sram_ce_n === 1'b1, "R1 ce_n", sram_ce_n, 1);
        chk(sram_oe_n === 1'b1, "R1 oe_n", sram_oe_n, 1);
        chk(sram_we_n === 1'b1, "R1 we_n", sram_we_n, 1);
        chk(sram_dout_en === 1'b0 && req_ack === 1'b0, "R1 drive/ack",
            {sram_dout_en, req_ack}, 0);

        // R2: power-up wait boundary
        rst_n = 1;
        n = 0; ack_seen = 0;
        while (sram_ce_n && n < 200) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (req_ack) ack_seen = 1;
        end
        chk(n == PWR_CK + 1, "R2 first select cycle", n, PWR_CK + 1);
        chk(!ack_seen, "R2 no ack during wait", ack_seen, 0);
        n = 0;
        while (!req_ack && n < 100) begin @(posedge clk); n++; @(negedge clk); end
        req_valid = 0;
        @(negedge clk);

        // Vector table walk: R3, R4, R5, R7, R9
        last_rd = 8'h00;
        foreach (VEC[i]) begin
            access(VEC[i][35], VEC[i][34:16], VEC[i][15:8], lat, ce_ack);
            chk(ce_ack === 1'b1, "R9 select high at ack", ce_ack, 1);
            @(negedge clk);
            chk(req_ack === 1'b0, "R9 single-cycle ack", req_ack, 0);
            if (VEC[i][35]) begin
                chk(lat == WR_LAT, "R7 write latency", lat, WR_LAT);
                chk(last_su == SU_CK, "R4 setup cycles", last_su, SU_CK);
                chk(last_pw == PW_CK, "R5 strobe cycles", last_pw, PW_CK);
                chk(last_ce == WRCE_CK, "R7 select cycles on write", last_ce, WRCE_CK);
                chk(req_rdata === last_rd, "R3 read data held over write", req_rdata, last_rd);
            end else begin
                chk(lat == RD_LAT, "R3 read latency", lat, RD_LAT);
                chk(last_ce == RD_CK, "R3 select cycles on read", last_ce, RD_CK);
                chk(req_rdata === VEC[i][7:0], "R9 read-back data", req_rdata, VEC[i][7:0]);
                last_rd = VEC[i][7:0];
            end
        end

        // R8: request inputs changed mid-access are ignored
        req_valid = 1; req_write = 1; req_addr = 19'h01234; req_wdata = 8'h66;
        @(posedge clk); @(negedge clk);
        req_addr = 19'h04321; req_wdata = 8'h99;
        n = 0;
        while (!req_ack && n < 100) begin @(posedge clk); n++; @(negedge clk); end
        req_valid = 0;
        chk(sram_addr === 19'h01234, "R8 address kept", sram_addr, 19'h01234);
        @(negedge clk);
        access(0, 19'h01234, 8'h00, lat, ce_ack);
        @(negedge clk);
        chk(req_rdata === 8'h66, "R8 latched write data", req_rdata, 8'h66);
        access(0, 19'h04321, 8'h00, lat, ce_ack);
        @(negedge clk);
        chk(req_rdata === 8'h00, "R8 other address untouched", req_rdata, 8'h00);

        // R2 / R9: the request pending through power-up was written
        access(0, 19'h00100, 8'h00, lat, ce_ack);
        @(negedge clk);
        chk(req_rdata === 8'h77, "R2 power-up request completed", req_rdata, 8'h77);

        // R6 / R8 / R5: bus monitor violations over the whole run
        chk(mon_err == 0, "R6 bus discipline", mon_err, 0);

        finish_up();
    end

endmodule